// File: doc/BRIEF.md
# ADC Conversion Result Queue

This block holds finished analog-to-digital conversion results until software or a DMA engine collects them. Each cycle the conversion sequencer may offer one result (a 12-bit value, an error bit and a valid strobe). When the queue is switched on, the block formats the result into a 16-bit entry and pushes it into a small first-in first-out store. Formatting can narrow the value to one byte, and can attach the error bit at a fixed bit position.

A reader sees the oldest entry on a combinational read port and removes it with a one-cycle pop strobe. Status outputs report the fill count, empty, full and two sticky error flags: one for a pop from an empty queue and one for a push into a full queue. Each flag has its own write-1 clear strobe. A programmable level threshold drives a raw interrupt and a DMA request, and the DMA request is gated by its own enable. The interrupt path ORs a force bit into the raw term and masks the result with an enable bit.

Occupancy is tracked by a three-state machine with the states OCC_EMPTY, OCC_PART and OCC_FULL. It has four transitions. FILL_FIRST goes from OCC_EMPTY to OCC_PART on an accepted push. FILL_LAST goes from OCC_PART to OCC_FULL when a lone push brings the count to the depth. DRAIN_LAST goes from OCC_PART to OCC_EMPTY when a lone pop takes the last entry. DRAIN_FROM_FULL goes from OCC_FULL to OCC_PART on a pop. Every other case stays in the current state.

Top module: `conv_result_queue`

## Requirements
- R1: A result is pushed only in a cycle where res_valid and q_enable are both 1. With q_enable at 0, res_valid has no effect on level or contents.
- R2: With shift_byte at 0, entry bits 11:0 hold the value and bits 14:12 are 0. With shift_byte at 1, bits 7:0 hold value bits 11:4 and bits 14:8 are 0.
- R3: With tag_err at 1, entry bit 15 equals the result's error bit in both formats. With tag_err at 0, bit 15 is 0.
- R4: rd_data shows the oldest held entry, and entries leave in push order. While the queue is empty, rd_data is 0.
- R5: level counts the held entries (0 to 4), empty is high at level 0 and full is high at level 4. A push and a pop in the same cycle on a queue that is neither empty nor full leave level unchanged.
- R6: A push while full is discarded, leaving level and contents unchanged, and sets over_flag. This holds even when a pop happens in the same cycle. A pulse on clr_over clears over_flag, and a set in the same cycle wins over the clear.
- R7: A pop while empty changes no pointer, reads 0 and sets under_flag. A pulse on clr_under clears under_flag, and a set in the same cycle wins over the clear.
- R8: irq_raw is 1 exactly when level >= level_thresh. dma_req is 1 exactly when irq_raw and dma_enable are both 1.
- R9: irq_out equals (irq_raw OR irq_force) AND irq_enable.
- R10: After reset the queue is empty, level is 0 and both sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion finished this cycle |
| res_value | input | 12 | Conversion value |
| res_err | input | 1 | Conversion error bit |
| q_enable | input | 1 | Push results into the queue |
| shift_byte | input | 1 | Narrow the value to its top 8 bits |
| tag_err | input | 1 | Store the error bit at entry bit 15 |
| dma_enable | input | 1 | Allow the DMA request |
| level_thresh | input | 4 | Level at or above which requests assert |
| rd_pop | input | 1 | Remove the oldest entry |
| rd_data | output | 16 | Oldest entry, 0 when empty |
| clr_over | input | 1 | Write-1 clear of over_flag |
| clr_under | input | 1 | Write-1 clear of under_flag |
| empty | output | 1 | No entries held |
| full | output | 1 | All entries held |
| level | output | 4 | Number of entries held |
| over_flag | output | 1 | Sticky: push arrived while full |
| under_flag | output | 1 | Sticky: pop arrived while empty |
| dma_req | output | 1 | DMA request |
| irq_raw | output | 1 | Raw threshold interrupt |
| irq_enable | input | 1 | Interrupt mask enable |
| irq_force | input | 1 | Interrupt force |
| irq_out | output | 1 | Masked interrupt status |

## Verification
The assertions assume the clear strobes are single-cycle pulses. In the overflow and underflow properties, the clear strobe of the same flag must be low in the cycle that sets it. The assertions also assume a depth of at least two, so that a single push from empty never reaches full directly. The bench changes inputs only on the falling clock edge and holds the configuration bits steady across every push it checks. It raises each clear strobe only in cycles of its own, apart from any set condition.

// File: rtl/crq_pkg.sv
package crq_pkg;

    // occupancy of the result store
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

endpackage

// File: rtl/crq_format.sv
module crq_format #(
    parameter int VAL_W     = 12,
    parameter int SHIFT_AMT = 4,
    parameter int ENTRY_W   = 16
) (
    input  logic [VAL_W-1:0]   val,
    input  logic               err,
    input  logic               shift_byte,
    input  logic               tag_err,
    output logic [ENTRY_W-1:0] entry
);
    localparam int ERR_BIT = ENTRY_W - 1;

    always_comb begin
        if (shift_byte) begin
            entry = ENTRY_W'(val >> SHIFT_AMT);
        end else begin
            entry = ENTRY_W'(val);
        end
        // the tag bit position does not depend on the shift
        entry[ERR_BIT] = tag_err & err;
    end

endmodule

// File: rtl/crq_store.sv
module crq_store
    import crq_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int ENTRY_W = 16,
    parameter int LVL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_req,
    input  logic [ENTRY_W-1:0] wr_entry,
    input  logic               pop_req,
    input  logic               clr_over,
    input  logic               clr_under,
    output logic [ENTRY_W-1:0] rd_entry,
    output logic [LVL_W-1:0]   level,
    output logic               empty,
    output logic               full,
    output logic               over_flag,
    output logic               under_flag
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] CNT_LAST = LVL_W'(DEPTH - 1);

    occ_e state, state_nxt;
    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]   wptr, rptr;
    logic [LVL_W-1:0]   count;
    logic               push_ok, pop_ok;

    assign push_ok = push_req && (state != OCC_FULL);
    assign pop_ok  = pop_req && (state != OCC_EMPTY);

    // next-state logic: the four named transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            OCC_EMPTY: if (push_ok) state_nxt = OCC_PART;                 // FILL_FIRST
            OCC_PART: begin
                if (push_ok && !pop_ok && count == CNT_LAST)
                    state_nxt = OCC_FULL;                                 // FILL_LAST
                else if (pop_ok && !push_ok && count == LVL_W'(1))
                    state_nxt = OCC_EMPTY;                                // DRAIN_LAST
            end
            OCC_FULL:  if (pop_ok) state_nxt = OCC_PART;                  // DRAIN_FROM_FULL
            default:   state_nxt = OCC_EMPTY;
        endcase
    end

    // state register, pointers, count and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= OCC_EMPTY;
            wptr       <= '0;
            rptr       <= '0;
            count      <= '0;
            over_flag  <= 1'b0;
            under_flag <= 1'b0;
        end else begin
            state <= state_nxt;
            if (push_ok) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
            if (push_req && state == OCC_FULL) over_flag <= 1'b1;
            else if (clr_over)                 over_flag <= 1'b0;
            if (pop_req && state == OCC_EMPTY) under_flag <= 1'b1;
            else if (clr_under)                under_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wr_entry;
    end

    // outputs decoded from the state register
    always_comb begin
        empty    = (state == OCC_EMPTY);
        full     = (state == OCC_FULL);
        level    = count;
        rd_entry = empty ? '0 : mem[rptr];
    end

endmodule

// File: rtl/crq_req.sv
module crq_req #(
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] level_thresh,
    input  logic             dma_enable,
    input  logic             irq_enable,
    input  logic             irq_force,
    output logic             irq_raw,
    output logic             dma_req,
    output logic             irq_out
);
    always_comb begin
        irq_raw = (level >= level_thresh);
        dma_req = irq_raw & dma_enable;
        irq_out = (irq_raw | irq_force) & irq_enable;
    end

endmodule

// File: rtl/conv_result_queue.sv
module conv_result_queue #(
    parameter int VAL_W     = 12,
    parameter int SHIFT_AMT = 4,
    parameter int ENTRY_W   = 16,
    parameter int DEPTH     = 4,
    parameter int LVL_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               res_valid,
    input  logic [VAL_W-1:0]   res_value,
    input  logic               res_err,
    input  logic               q_enable,
    input  logic               shift_byte,
    input  logic               tag_err,
    input  logic               dma_enable,
    input  logic [LVL_W-1:0]   level_thresh,
    input  logic               rd_pop,
    output logic [ENTRY_W-1:0] rd_data,
    input  logic               clr_over,
    input  logic               clr_under,
    output logic               empty,
    output logic               full,
    output logic [LVL_W-1:0]   level,
    output logic               over_flag,
    output logic               under_flag,
    output logic               dma_req,
    output logic               irq_raw,
    input  logic               irq_enable,
    input  logic               irq_force,
    output logic               irq_out
);
    logic [ENTRY_W-1:0] fmt_entry;
    logic               push_req;

    assign push_req = res_valid & q_enable;

    crq_format #(
        .VAL_W(VAL_W), .SHIFT_AMT(SHIFT_AMT), .ENTRY_W(ENTRY_W)
    ) u_format (
        .val(res_value), .err(res_err), .shift_byte(shift_byte),
        .tag_err(tag_err), .entry(fmt_entry)
    );

    crq_store #(
        .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .LVL_W(LVL_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .wr_entry(fmt_entry),
        .pop_req(rd_pop), .clr_over(clr_over), .clr_under(clr_under),
        .rd_entry(rd_data), .level(level), .empty(empty), .full(full),
        .over_flag(over_flag), .under_flag(under_flag)
    );

    crq_req #(
        .LVL_W(LVL_W)
    ) u_req (
        .level(level), .level_thresh(level_thresh), .dma_enable(dma_enable),
        .irq_enable(irq_enable), .irq_force(irq_force),
        .irq_raw(irq_raw), .dma_req(dma_req), .irq_out(irq_out)
    );

endmodule

// File: rtl/crq_checker.sv
module crq_checker #(
    parameter int ENTRY_W = 16,
    parameter int DEPTH   = 4,
    parameter int LVL_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               res_valid,
    input logic               q_enable,
    input logic               rd_pop,
    input logic               clr_over,
    input logic               clr_under,
    input logic [ENTRY_W-1:0] rd_data,
    input logic               empty,
    input logic               full,
    input logic [LVL_W-1:0]   level,
    input logic [LVL_W-1:0]   level_thresh,
    input logic               over_flag,
    input logic               under_flag,
    input logic               dma_req,
    input logic               irq_raw,
    input logic               irq_enable,
    input logic               irq_out
);
    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    assert_empty_full_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(res_valid && q_enable) && !rd_pop) |=> $stable(level));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && res_valid && q_enable && !rd_pop) |=> (full && level == LVL_W'(DEPTH)));

    assert_over_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && res_valid && q_enable && !clr_over) |=> over_flag);

    assert_under_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_pop && !clr_under) |=> under_flag);

    assert_empty_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rd_data == '0));

    assert_dma_needs_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (irq_raw && level >= level_thresh));

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> irq_enable);

endmodule

bind conv_result_queue crq_checker #(
    .ENTRY_W(ENTRY_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .q_enable(q_enable),
    .rd_pop(rd_pop), .clr_over(clr_over), .clr_under(clr_under),
    .rd_data(rd_data), .empty(empty), .full(full), .level(level),
    .level_thresh(level_thresh), .over_flag(over_flag), .under_flag(under_flag),
    .dma_req(dma_req), .irq_raw(irq_raw), .irq_enable(irq_enable), .irq_out(irq_out)
);

// File: tb/conv_result_queue_bench.sv
`timescale 1ns/1ps
module conv_result_queue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_value = '0;
    logic        res_err = 1'b0;
    logic        q_enable = 1'b1;
    logic        shift_byte = 1'b0;
    logic        tag_err = 1'b1;
    logic        dma_enable = 1'b0;
    logic [3:0]  level_thresh = 4'd1;
    logic        rd_pop = 1'b0;
    logic [15:0] rd_data;
    logic        clr_over = 1'b0;
    logic        clr_under = 1'b0;
    logic        empty, full, over_flag, under_flag, dma_req, irq_raw, irq_out;
    logic [3:0]  level;
    logic        irq_enable = 1'b0;
    logic        irq_force = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    conv_result_queue u_conv_result_queue (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
        .res_err(res_err), .q_enable(q_enable), .shift_byte(shift_byte),
        .tag_err(tag_err), .dma_enable(dma_enable), .level_thresh(level_thresh),
        .rd_pop(rd_pop), .rd_data(rd_data), .clr_over(clr_over),
        .clr_under(clr_under), .empty(empty), .full(full), .level(level),
        .over_flag(over_flag), .under_flag(under_flag), .dma_req(dma_req),
        .irq_raw(irq_raw), .irq_enable(irq_enable), .irq_force(irq_force),
        .irq_out(irq_out)
    );

    // {push, value[11:0], err, pop, level after, head after}
    localparam logic [34:0] VEC [7] = '{
        {1'b1, 12'hABC, 1'b0, 1'b0, 4'd1, 16'h0ABC},
        {1'b1, 12'h123, 1'b1, 1'b0, 4'd2, 16'h0ABC},
        {1'b0, 12'h000, 1'b0, 1'b1, 4'd1, 16'h8123},
        {1'b1, 12'h456, 1'b0, 1'b1, 4'd1, 16'h0456},
        {1'b1, 12'h7FF, 1'b0, 1'b0, 4'd2, 16'h0456},
        {1'b0, 12'h000, 1'b0, 1'b1, 4'd1, 16'h07FF},
        {1'b0, 12'h000, 1'b0, 1'b1, 4'd0, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock with the given strobes, checked one time unit after the edge
    task automatic step(input logic push, input logic [11:0] v, input logic e, input logic pop);
        @(negedge clk);
        res_valid = push; res_value = v; res_err = e; rd_pop = pop;
        @(posedge clk);
        #1;
        res_valid = 1'b0; rd_pop = 1'b0;
    endtask

    task automatic pulse_clear(input logic ov, input logic un);
        @(negedge clk);
        clr_over = ov; clr_under = un;
        @(posedge clk);
        #1;
        clr_over = 1'b0; clr_under = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10 empty", 32'(empty), 32'd1);
        chk("R10 level", 32'(level), 32'd0);
        chk("R10 flags", {30'd0, over_flag, under_flag}, 32'd0);
        chk("R4 zero read", 32'(rd_data), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // table: order, tagging, simultaneous push/pop (R4 R5 R3)
        for (int i = 0; i < 7; i++) begin
            step(VEC[i][34], VEC[i][33:22], VEC[i][21], VEC[i][20]);
            chk("R5 level", 32'(level), 32'(VEC[i][19:16]));
            chk("R4 head", 32'(rd_data), 32'(VEC[i][15:0]));
        end

        // R2 R3: shifted with tag
        shift_byte = 1'b1;
        step(1'b1, 12'hABC, 1'b1, 1'b0);
        chk("R2 shifted tagged", 32'(rd_data), 32'h80AB);
        step(1'b0, 12'h0, 1'b0, 1'b1);
        // R3: tag disabled, unshifted
        shift_byte = 1'b0; tag_err = 1'b0;
        step(1'b1, 12'hABC, 1'b1, 1'b0);
        chk("R3 untagged", 32'(rd_data), 32'h0ABC);
        step(1'b0, 12'h0, 1'b0, 1'b1);
        // R2: tag disabled, shifted
        shift_byte = 1'b1;
        step(1'b1, 12'h5F0, 1'b1, 1'b0);
        chk("R2 shifted untagged", 32'(rd_data), 32'h005F);
        step(1'b0, 12'h0, 1'b0, 1'b1);
        shift_byte = 1'b0; tag_err = 1'b1;

        // R1: queue disabled ignores results
        q_enable = 1'b0;
        step(1'b1, 12'h321, 1'b0, 1'b0);
        chk("R1 disabled level", 32'(level), 32'd0);
        chk("R1 disabled empty", 32'(empty), 32'd1);
        q_enable = 1'b1;

        // R5: fill to full
        for (int k = 1; k <= 4; k++) step(1'b1, 12'(k), 1'b0, 1'b0);
        chk("R5 full", 32'(full), 32'd1);
        chk("R5 full level", 32'(level), 32'd4);

        // R8: threshold and DMA gate
        level_thresh = 4'd4; dma_enable = 1'b0;
        #1;
        chk("R8 raw at thresh", 32'(irq_raw), 32'd1);
        chk("R8 dma gated", 32'(dma_req), 32'd0);
        dma_enable = 1'b1;
        #1;
        chk("R8 dma on", 32'(dma_req), 32'd1);
        level_thresh = 4'd5;
        #1;
        chk("R8 below thresh", 32'(irq_raw), 32'd0);
        chk("R8 dma below", 32'(dma_req), 32'd0);

        // R6: push to full discarded
        step(1'b1, 12'hFFF, 1'b1, 1'b0);
        chk("R6 over set", 32'(over_flag), 32'd1);
        chk("R6 level kept", 32'(level), 32'd4);
        chk("R6 head kept", 32'(rd_data), 32'h0001);
        pulse_clear(1'b1, 1'b0);
        chk("R6 over cleared", 32'(over_flag), 32'd0);
        // R6: push plus pop while full: push dropped
        step(1'b1, 12'hEEE, 1'b0, 1'b1);
        chk("R6 full push+pop level", 32'(level), 32'd3);
        chk("R6 full push+pop flag", 32'(over_flag), 32'd1);
        pulse_clear(1'b1, 1'b0);
        // R8: level 3 below threshold 4
        level_thresh = 4'd4;
        #1;
        chk("R8 level3 thresh4", 32'(irq_raw), 32'd0);
        // R4: drain order, 0xEEE never stored
        step(1'b0, 12'h0, 1'b0, 1'b1);
        chk("R4 order 3", 32'(rd_data), 32'h0003);
        step(1'b0, 12'h0, 1'b0, 1'b1);
        chk("R4 order 4", 32'(rd_data), 32'h0004);
        step(1'b0, 12'h0, 1'b0, 1'b1);
        chk("R5 drained", 32'(empty), 32'd1);
        dma_enable = 1'b0;

        // R9: interrupt mask and force
        level_thresh = 4'd1; irq_enable = 1'b0; irq_force = 1'b1;
        #1;
        chk("R9 masked force", 32'(irq_out), 32'd0);
        irq_enable = 1'b1;
        #1;
        chk("R9 forced", 32'(irq_out), 32'd1);
        irq_force = 1'b0;
        #1;
        chk("R9 idle", 32'(irq_out), 32'd0);
        step(1'b1, 12'h010, 1'b0, 1'b0);
        chk("R9 raw passes", 32'(irq_out), 32'd1);
        step(1'b0, 12'h0, 1'b0, 1'b1);

        // R7: pop from empty
        step(1'b0, 12'h0, 1'b0, 1'b1);
        chk("R7 under set", 32'(under_flag), 32'd1);
        chk("R7 level", 32'(level), 32'd0);
        chk("R7 read zero", 32'(rd_data), 32'd0);
        step(1'b1, 12'h0AA, 1'b0, 1'b0);
        chk("R7 pointers kept", 32'(rd_data), 32'h00AA);
        pulse_clear(1'b0, 1'b1);
        chk("R7 under cleared", 32'(under_flag), 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule